// File: doc/BRIEF.md
# ECC Partial-Store Merge Unit with Silent-Write Suppression

This unit carries out stores into a data cache whose words are 64 data bits protected by eight SECDED check bits. A store narrower than the protected word (8, 16 or 32 bits) becomes a read-modify-write. The unit reads the stored word, checks and corrects it, and overlays the new bytes. It then encodes fresh check bits and writes the word back. In the same cycle as correction and encoding, it compares the new bytes with the corrected old bytes. No extra cycle is spent on this comparison.

When every written byte already holds its new value and the word read back was clean, the write-back is dropped and a one-cycle squash pulse is raised for statistics counters. A corrected single-bit error always forces the write, so that the repaired word reaches the array. A double-bit error blocks the write and raises a one-cycle uncorrectable pulse. A full 64-bit store skips the read and is always written.

The store request is a valid/ready stream. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. While `req_valid` is high and `req_ready` is low, the requester must hold every request field stable. `req_ready` is high only when the unit is idle, so one store is in flight at a time. The array port has no back-pressure: a read returns data one cycle after `arr_rd_en`, and a write is taken on the edge that ends an `arr_wr_en` cycle. The status pins are plain one-cycle pulses.

Top module: `ecc_merge_store`

## Requirements
- R1: `req_ready` is high only while idle, and drops for the cycles after an acceptance. For a sub-word store accepted at edge E0, the read request appears in the first cycle after E0. The write and status cycle is the third cycle after E0, and `req_ready` returns in the fourth. A request that is held valid while `req_ready` is low starts no array access.
- R2: `req_size` selects the width: 0 is a byte, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. Store data is taken from the low bits of `req_data`. Byte lane n holds data bits 8n+7..8n. `req_off` selects the lane. For 16-bit stores bit 0 of the offset is ignored, and for 32-bit stores bits 1..0 are ignored.
- R3: A 64-bit store issues no read. It writes `req_data` and its check bits in the first cycle after acceptance, and `req_ready` returns in the second.
- R4: A sub-word store that is written puts the corrected old word, with the selected lanes replaced, on `arr_wr_data`, at the address of the request.
- R5: A sub-word store whose bytes all equal the old bytes, on a clean read, makes no write. It pulses `st_squash` and `st_silent` together with `st_done`.
- R6: A single-bit error in the read word, whether in a data bit, a Hamming bit or the overall parity bit, pulses `st_corrected`. It always writes the corrected, merged word, even when the store is silent.
- R7: A double-bit error pulses `st_uncorr` and blocks the write. `st_squash` and `st_silent` stay low.
- R8: Silence is judged against the corrected old data. A store whose bytes equal the corrected value of a lane that holds a flipped bit pulses `st_silent`, and the write is still issued.
- R9: Check bit layout: data bit i takes the i-th position, counting upward, in the range 3..71 that is not a power of two. `arr_wr_chk[k]` for k = 0..6 is the XOR of the data bits whose position has bit k set. `arr_wr_chk[7]` gives even parity over all 72 bits.
- R10: `st_done` pulses for exactly one cycle per store, in its write/status cycle. `arr_wr_en`, `st_squash` and `st_uncorr` are never high outside that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit idle; request taken when valid is also high |
| req_addr | input | AW | Word address |
| req_off | input | 3 | Byte offset within the word |
| req_size | input | 2 | Store width code (R2) |
| req_data | input | 64 | Store data, right-aligned |
| arr_rd_en | output | 1 | Array read request |
| arr_rd_addr | output | AW | Array read address |
| arr_rd_data | input | 64 | Array read data, one cycle after the request |
| arr_rd_chk | input | 8 | Array read check bits |
| arr_wr_en | output | 1 | Array write enable |
| arr_wr_addr | output | AW | Array write address |
| arr_wr_data | output | 64 | Array write data |
| arr_wr_chk | output | 8 | Array write check bits |
| st_done | output | 1 | One pulse per completed store |
| st_squash | output | 1 | Write dropped because the store was silent |
| st_corrected | output | 1 | Single-bit error corrected |
| st_uncorr | output | 1 | Double-bit error detected |
| st_silent | output | 1 | Store matched the corrected old bytes |

## Verification
Error correction and silence detection can land on the same store in the same check cycle. This is provoked by flipping one bit of the word the array model returns while storing values that match the stored bytes. The flip is placed both in an untouched lane and in the very lane being stored, and also in a check bit. Such a case is judged correct when the write is still issued with the repaired, merged word and fresh check bits, with `st_silent` and `st_corrected` both pulsing and `st_squash` low. The bench also follows each stored word in its own model, so a wrongly dropped or wrongly issued write shows up on later stores to the same address.

// File: rtl/ecc_store_pkg.sv
package ecc_store_pkg;

  localparam int DATA_W   = 64;
  localparam int HAM_W    = 7;
  localparam int CHK_W    = HAM_W + 1;
  localparam int LANES    = DATA_W / 8;
  localparam int OFF_W    = $clog2(LANES);
  localparam int CODE_MAX = DATA_W + HAM_W;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WRITE
  } phase_e;

  // Codeword position of data bit idx: the idx-th non-power-of-two from 3 up.
  function automatic int code_pos(int idx);
    int cnt;
    cnt = 0;
    for (int p = 1; p <= CODE_MAX; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  // Data bits feeding Hamming check bit k.
  function automatic logic [DATA_W-1:0] cover_mask(int k);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (((code_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_store_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  logic [HAM_W-1:0] ham;

  for (genvar k = 0; k < HAM_W; k++) begin : g_ham
    localparam logic [DATA_W-1:0] COVER = cover_mask(k);
    assign ham[k] = ^(data & COVER);
  end

  assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_store_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [DATA_W-1:0] data_fix,
  output logic              err_single,
  output logic              err_double
);

  logic [CHK_W-1:0]  recalc;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic [DATA_W-1:0] flip;

  secded_enc u_recalc (
    .data (data),
    .chk  (recalc)
  );

  assign syn = recalc[HAM_W-1:0] ^ chk[HAM_W-1:0];
  assign odd = ^{data, chk};

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int POS = code_pos(i);
    assign flip[i] = odd && (syn == HAM_W'(POS));
  end

  assign data_fix   = data ^ flip;
  assign err_single = odd && (syn <= HAM_W'(CODE_MAX));
  assign err_double = (!odd && (syn != '0)) || (odd && (syn > HAM_W'(CODE_MAX)));

endmodule

// File: rtl/store_lane_merge.sv
module store_lane_merge
  import ecc_store_pkg::*;
(
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_raw,
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] merged,
  output logic              silent
);

  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] rep;
  logic [LANES-1:0]  same;

  always_comb begin
    case (size_e'(size))
      SZ_BYTE: begin
        lane_en = LANES'(1) << off;
        rep     = {LANES{new_raw[7:0]}};
      end
      SZ_HALF: begin
        lane_en = LANES'(2'b11) << {off[OFF_W-1:1], 1'b0};
        rep     = {(LANES/2){new_raw[15:0]}};
      end
      SZ_WORD: begin
        lane_en = LANES'(4'hF) << {off[OFF_W-1], 2'b00};
        rep     = {(LANES/4){new_raw[31:0]}};
      end
      default: begin
        lane_en = '1;
        rep     = new_raw;
      end
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[8*l +: 8] = lane_en[l] ? rep[8*l +: 8] : old_word[8*l +: 8];
    assign same[l]          = !lane_en[l] || (rep[8*l +: 8] == old_word[8*l +: 8]);
  end

  assign silent = &same;

endmodule

// File: rtl/ecc_merge_store.sv
module ecc_merge_store
  import ecc_store_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [2:0]        req_off,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_data,
  output logic              arr_rd_en,
  output logic [AW-1:0]     arr_rd_addr,
  input  logic [63:0]       arr_rd_data,
  input  logic [7:0]        arr_rd_chk,
  output logic              arr_wr_en,
  output logic [AW-1:0]     arr_wr_addr,
  output logic [63:0]       arr_wr_data,
  output logic [7:0]        arr_wr_chk,
  output logic              st_done,
  output logic              st_squash,
  output logic              st_corrected,
  output logic              st_uncorr,
  output logic              st_silent
);

  phase_e            phase_q;
  logic [AW-1:0]     addr_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] data_q;

  logic              wr_en_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [CHK_W-1:0]  wr_chk_q;
  logic              done_q, squash_q, corr_q, uncorr_q, silent_q;

  logic              accept;
  logic              is_full;
  logic [CHK_W-1:0]  full_chk;
  logic [DATA_W-1:0] old_fix;
  logic              e_single, e_double;
  logic [DATA_W-1:0] merged;
  logic              same_bytes;
  logic [CHK_W-1:0]  merge_chk;
  logic              keep_write;

  assign req_ready = (phase_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_full   = (size_e'(req_size) == SZ_DWORD);

  // Full-word path: encode straight from the request.
  secded_enc u_enc_full (
    .data (req_data),
    .chk  (full_chk)
  );

  // Partial path: correct, merge and compare, then re-encode, all in one cycle.
  secded_dec u_dec (
    .data       (arr_rd_data),
    .chk        (arr_rd_chk),
    .data_fix   (old_fix),
    .err_single (e_single),
    .err_double (e_double)
  );

  store_lane_merge u_merge (
    .old_word (old_fix),
    .new_raw  (data_q),
    .size     (size_q),
    .off      (off_q),
    .merged   (merged),
    .silent   (same_bytes)
  );

  secded_enc u_enc_merge (
    .data (merged),
    .chk  (merge_chk)
  );

  assign keep_write = !e_double && (!same_bytes || e_single);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= ST_IDLE;
      addr_q    <= '0;
      off_q     <= '0;
      size_q    <= '0;
      data_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
      wr_chk_q  <= '0;
      done_q    <= 1'b0;
      squash_q  <= 1'b0;
      corr_q    <= 1'b0;
      uncorr_q  <= 1'b0;
      silent_q  <= 1'b0;
    end else begin
      wr_en_q  <= 1'b0;
      done_q   <= 1'b0;
      squash_q <= 1'b0;
      corr_q   <= 1'b0;
      uncorr_q <= 1'b0;
      silent_q <= 1'b0;
      case (phase_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q <= req_addr;
            off_q  <= req_off;
            size_q <= req_size;
            data_q <= req_data;
            if (is_full) begin
              wr_en_q   <= 1'b1;
              wr_data_q <= req_data;
              wr_chk_q  <= full_chk;
              done_q    <= 1'b1;
              phase_q   <= ST_WRITE;
            end else begin
              phase_q <= ST_READ;
            end
          end
        end
        ST_READ: phase_q <= ST_CHECK;
        ST_CHECK: begin
          wr_en_q   <= keep_write;
          wr_data_q <= merged;
          wr_chk_q  <= merge_chk;
          done_q    <= 1'b1;
          squash_q  <= !e_double && same_bytes && !e_single;
          corr_q    <= e_single;
          uncorr_q  <= e_double;
          silent_q  <= !e_double && same_bytes;
          phase_q   <= ST_WRITE;
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign arr_rd_en    = (phase_q == ST_READ);
  assign arr_rd_addr  = addr_q;
  assign arr_wr_en    = wr_en_q;
  assign arr_wr_addr  = addr_q;
  assign arr_wr_data  = wr_data_q;
  assign arr_wr_chk   = wr_chk_q;
  assign st_done      = done_q;
  assign st_squash    = squash_q;
  assign st_corrected = corr_q;
  assign st_uncorr    = uncorr_q;
  assign st_silent    = silent_q;

endmodule

// File: rtl/ecc_merge_store_chk.sv
module ecc_merge_store_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_size,
  input logic       arr_rd_en,
  input logic       arr_wr_en,
  input logic       st_done,
  input logic       st_squash,
  input logic       st_corrected,
  input logic       st_uncorr,
  input logic       st_silent
);

  p_wr_not_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> !req_ready);

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_read_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |=> !arr_rd_en);

  p_sub_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != 2'd3) |=> arr_rd_en);

  p_full_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == 2'd3) |=> (arr_wr_en && !arr_rd_en));

  p_squash_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_squash |-> (!arr_wr_en && st_silent));

  p_corrected_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_corrected |-> arr_wr_en);

  p_uncorr_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_uncorr |-> (!arr_wr_en && !st_squash && !st_silent));

  p_outputs_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en || st_squash || st_uncorr) |-> st_done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> !st_done);

endmodule

bind ecc_merge_store ecc_merge_store_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_size     (req_size),
  .arr_rd_en    (arr_rd_en),
  .arr_wr_en    (arr_wr_en),
  .st_done      (st_done),
  .st_squash    (st_squash),
  .st_corrected (st_corrected),
  .st_uncorr    (st_uncorr),
  .st_silent    (st_silent)
);

// File: tb/ecc_merge_store_tb_top.sv
`timescale 1ns/1ps
module ecc_merge_store_tb_top;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_off = '0;
  logic [1:0]    req_size = '0;
  logic [63:0]   req_data = '0;
  logic          arr_rd_en;
  logic [AW-1:0] arr_rd_addr;
  logic [63:0]   arr_rd_data;
  logic [7:0]    arr_rd_chk;
  logic          arr_wr_en;
  logic [AW-1:0] arr_wr_addr;
  logic [63:0]   arr_wr_data;
  logic [7:0]    arr_wr_chk;
  logic          st_done, st_squash, st_corrected, st_uncorr, st_silent;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  ecc_merge_store #(.AW(AW)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_off, .req_size,
    .req_data, .arr_rd_en, .arr_rd_addr, .arr_rd_data, .arr_rd_chk,
    .arr_wr_en, .arr_wr_addr, .arr_wr_data, .arr_wr_chk, .st_done,
    .st_squash, .st_corrected, .st_uncorr, .st_silent
  );

  // Array model: one-cycle read, flip mask applied to the word returned.
  logic [71:0] mem [0:(1<<AW)-1];
  logic [71:0] rd_q = '0;
  logic [71:0] flip = '0;
  always @(posedge clk) begin
    if (arr_rd_en) rd_q <= mem[arr_rd_addr] ^ flip;
    if (arr_wr_en) mem[arr_wr_addr] <= {arr_wr_chk, arr_wr_data};
  end
  assign arr_rd_data = rd_q[63:0];
  assign arr_rd_chk  = rd_q[71:64];

  logic [63:0] ref_mem [0:(1<<AW)-1];

  // Reference encoder: build the 71-position codeword and fold parities.
  function automatic logic [7:0] ref_enc(input logic [63:0] d);
    logic [71:0] cw;
    logic [7:0]  c;
    int          idx;
    cw = '0;
    idx = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[idx];
        idx++;
      end
    end
    for (int k = 0; k < 7; k++) begin
      c[k] = 1'b0;
      for (int p = 1; p <= 71; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k)) c[k] = c[k] ^ cw[p];
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [63:0] ref_merge(input logic [63:0] old, input logic [63:0] d,
                                            input logic [2:0] off, input logic [1:0] sz);
    logic [63:0] r;
    int nb;
    nb = 1 << sz;
    r = old;
    for (int b = 0; b < 8; b++)
      if ((b / nb) == (off / nb)) r[8*b +: 8] = d[8*(b % nb) +: 8];
    return r;
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare all control/status outputs with the model for this cycle.
  task automatic check_cycle(input string req, input logic [7:0] exp_v,
                             input logic [AW-1:0] a, input logic [63:0] wd,
                             input logic [7:0] wc);
    logic [7:0] act_v;
    act_v = {req_ready, arr_rd_en, arr_wr_en, st_done, st_squash, st_corrected,
             st_uncorr, st_silent};
    cmp(req, "ctl{rdy,rd,wr,done,sq,cor,unc,sil}", {56'd0, act_v}, {56'd0, exp_v});
    if (exp_v[6]) cmp(req, "rd_addr", {56'd0, arr_rd_addr}, {56'd0, a});
    if (exp_v[5]) begin
      cmp(req, "wr_addr", {56'd0, arr_wr_addr}, {56'd0, a});
      cmp(req, "wr_data", arr_wr_data, wd);
      cmp({req, " R9"}, "wr_chk", {56'd0, arr_wr_chk}, {56'd0, wc});
    end
  endtask

  task automatic do_store(input string req, input logic [AW-1:0] a, input logic [2:0] off,
                          input logic [1:0] sz, input logic [63:0] d,
                          input logic [71:0] fl, input bit hold);
    logic [63:0] old, m;
    bit sil, one, two, wr, sq;
    old = ref_mem[a];
    m   = (sz == 2'd3) ? d : ref_merge(old, d, off, sz);
    one = ($countones(fl) == 1);
    two = ($countones(fl) == 2);
    sil = (sz != 2'd3) && (m == old) && !two;
    wr  = (sz == 2'd3) || (!two && (!sil || one));
    sq  = sil && !one;
    @(negedge clk);
    check_cycle({req, " R1 ready"}, 8'b1000_0000, a, '0, '0);
    req_valid = 1'b1; req_addr = a; req_off = off; req_size = sz; req_data = d;
    flip = (sz == 2'd3) ? '0 : fl;
    @(negedge clk);
    req_valid = hold;
    if (sz == 2'd3) begin
      check_cycle({req, " R3"}, 8'b0011_0000, a, d, ref_enc(d));
    end else begin
      check_cycle({req, " R1 read"}, 8'b0100_0000, a, '0, '0);
      @(negedge clk);
      check_cycle({req, " R1 wait"}, 8'b0000_0000, a, '0, '0);
      @(negedge clk);
      check_cycle({req, " R10"}, {2'b00, wr, 1'b1, sq, one, two, sil}, a, m, ref_enc(m));
      req_valid = 1'b0;
    end
    flip = '0;
    if (wr) ref_mem[a] = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_cycle("R1 reset", 8'b1000_0000, '0, '0, '0);
    rst_n = 1'b1;

    // R3: initialise words with full stores
    do_store("R3 full a1", 8'd1, 3'd0, 2'd3, 64'h0123_4567_89AB_CDEF, '0, 0);
    do_store("R3 full a2", 8'd2, 3'd5, 2'd3, 64'hFEDC_BA98_7654_3210, '0, 0);
    do_store("R3 full a3", 8'd3, 3'd0, 2'd3, 64'h5555_AAAA_0F0F_F0F0, '0, 0);
    do_store("R3 full a4", 8'd4, 3'd0, 2'd3, 64'h1122_3344_5566_7788, '0, 0);
    do_store("R3 full a5", 8'd5, 3'd0, 2'd3, 64'hDEAD_BEEF_CAFE_F00D, '0, 0);

    // R2/R4: byte store, then R5 the same byte again is silent
    do_store("R4 byte", 8'd1, 3'd5, 2'd0, 64'hA5, '0, 0);
    do_store("R5 byte silent", 8'd1, 3'd5, 2'd0, 64'hA5, '0, 0);
    // R2: half store at odd offset uses lanes 2..3; silent repeat at offset 2
    do_store("R2 half off3", 8'd2, 3'd3, 2'd1, 64'h1234, '0, 0);
    do_store("R5 half silent", 8'd2, 3'd2, 2'd1, 64'h1234, '0, 0);
    // R2: word store, offset bits 1..0 ignored
    do_store("R2 word off7", 8'd3, 3'd7, 2'd2, 64'hCAFE_BABE, '0, 0);
    do_store("R5 word silent", 8'd3, 3'd0, 2'd2, {32'd0, ref_mem[3][31:0]}, '0, 0);

    // R6: data bit flipped in an untouched lane, silent store still writes
    do_store("R6 flip data", 8'd4, 3'd0, 2'd0, {56'd0, ref_mem[4][7:0]}, 72'd1 << 40, 0);
    // R8: flipped bit inside the stored lane, store equals corrected byte
    do_store("R8 flip lane", 8'd4, 3'd2, 2'd0, {56'd0, ref_mem[4][23:16]}, 72'd1 << 17, 0);
    // R6: Hamming check bit and overall parity bit flipped
    do_store("R6 flip chk3", 8'd5, 3'd4, 2'd1, {48'd0, ref_mem[5][47:32]}, 72'd1 << 67, 0);
    do_store("R6 flip ovp", 8'd5, 3'd0, 2'd1, 64'h7777, 72'd1 << 71, 0);
    // R7: two flipped bits block the write, word stays as before
    do_store("R7 double", 8'd5, 3'd1, 2'd0, 64'h3C, (72'd1 << 3) | (72'd1 << 50), 0);
    do_store("R7 after double", 8'd5, 3'd1, 2'd0, {56'd0, ref_mem[5][15:8]}, '0, 0);

    // R1: request held valid while busy starts nothing extra
    do_store("R1 hold", 8'd3, 3'd6, 2'd0, 64'h99, '0, 1);
    do_store("R1 after hold", 8'd3, 3'd6, 2'd0, 64'h99, '0, 0);
    do_store("R3 overwrite", 8'd4, 3'd0, 2'd3, 64'h0, '0, 0);
    do_store("R4 byte top", 8'd4, 3'd7, 2'd0, 64'hFF, '0, 0);

    @(negedge clk);
    check_cycle("R1 final idle", 8'b1000_0000, '0, '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule